// File: doc/BRIEF.md
# Mask Prefix-to-First-Set Unit

This unit builds a new mask register from a source mask in one of three ways. Each way depends on where the lowest active set bit of the source lies. One mode sets every destination bit below that position. A second mode also sets the bit at that position. A third mode sets only that one bit. A single "already found" flag runs through the elements in ascending order, and the chosen mode turns that flag and the current source bit into the destination bit.

An operation starts with a one-cycle `start` while the unit is idle. On that cycle the unit captures the source mask, the execution mask and the old destination contents. It then handles one element per cycle. Elements that are inactive under the execution mask, and elements at or above the vector length, keep their old destination bits. When the operation ends, `done` pulses for one cycle with the merged result on `newDest`.

Two register combinations are rejected, and so is the reserved mode code. These operations finish after one cycle with `illegal` raised and the old destination unchanged.

Top module: `mask_first_unit`

## Requirements
- R1: Mode code 2'b00 (before) writes 1 to an active element while no active set source bit has been seen and its own source bit is 0. From the first active set source bit onward it writes 0.
- R2: Mode code 2'b01 (including) writes 1 to every active element up to and including the first active set source bit, and 0 to active elements after it.
- R3: Mode code 2'b10 (only) writes 1 solely at the lowest-indexed active element whose source bit is 1, and 0 at every other active element.
- R4: When `vm`=0, an element i with `execMask[i]`=0 keeps `oldDest[i]` and does not count as the first set bit, even if `srcMask[i]`=1.
- R5: Destination bits at index `vl` and above keep their `oldDest` values.
- R6: When `vm`=1, every element below `vl` is active and `execMask` has no effect.
- R7: `vdIdx` equal to `vs2Idx`, or `vm`=0 with `vdIdx`=0, makes the operation illegal.
- R8: Mode code 2'b11 is reserved and makes the operation illegal.
- R9: An illegal operation raises `illegal` during its `done` cycle and returns `newDest` equal to the captured `oldDest`. `illegal` is never high outside a `done` cycle.
- R10: A legal operation with vl=N>0 raises `done` N+1 clock edges after the edge that samples `start`. An illegal operation, or one with vl=0, raises it after 1 edge.
- R11: `done` lasts one cycle. `newDest` holds its value while the unit is idle and no start arrives.
- R12: A `start` that arrives while the unit is busy is ignored. It changes neither the result in progress nor the number of `done` pulses.
- R13: After reset, `busy`, `done` and `illegal` are 0 and `newDest` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opSel | input | 2 | Mode: 00 before, 01 including, 10 only, 11 reserved |
| vm | input | 1 | 1 = unmasked (all elements active) |
| vl | input | $clog2(VLEN+1) | Number of elements to process |
| vdIdx | input | REG_IDX_W | Destination register index |
| vs2Idx | input | REG_IDX_W | Source register index |
| srcMask | input | VLEN | Source mask contents |
| execMask | input | VLEN | Execution mask contents (used when vm=0) |
| oldDest | input | VLEN | Current destination contents |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Operation rejected (valid with done) |
| newDest | output | VLEN | Merged destination result |

## Verification
The bench builds the unit with VLEN=16. With that width a vector length equal to the full register can be run, and a full element-by-element operation takes only 17 cycles. Random runs can therefore cover every vl from 0 to 16, all four mode codes, and register indices drawn from a small range so that overlaps and v0 conflicts come up often. At this width the tail bits (R5) and the inactive-element rule (R4) can be seen on every bit position.

// File: rtl/mfo_pkg.sv
package mfo_pkg;
  typedef enum logic [1:0] {
    OP_BEFORE = 2'b00,
    OP_INCL   = 2'b01,
    OP_ONLY   = 2'b10,
    OP_RSVD   = 2'b11
  } opSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } state_e;

  typedef struct packed {
    logic load;  // capture operands, reset the walk
    logic step;  // process one element
  } ctrlStrobe_t;
endpackage

// File: rtl/mfo_ctrl.sv
module mfo_ctrl
  import mfo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        startBad,
  input  logic        lastElem,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = startBad ? ST_FIN : ST_RUN;
      ST_RUN:  if (lastElem) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/mfo_datapath.sv
module mfo_datapath
  import mfo_pkg::*;
#(
  parameter int VLEN      = 64,
  parameter int REG_IDX_W = 5,
  localparam int IDX_W    = (VLEN > 1) ? $clog2(VLEN) : 1,
  localparam int VL_W     = $clog2(VLEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [1:0]           opSel,
  input  logic                 vm,
  input  logic [VL_W-1:0]      vl,
  input  logic [REG_IDX_W-1:0] vdIdx,
  input  logic [REG_IDX_W-1:0] vs2Idx,
  input  logic [VLEN-1:0]      srcMask,
  input  logic [VLEN-1:0]      execMask,
  input  logic [VLEN-1:0]      oldDest,
  output logic                 startBad,
  output logic                 lastElem,
  output logic                 illFlag,
  output logic [VLEN-1:0]      destOut
);
  logic [VLEN-1:0] srcSnap, actSnap, destReg, bitWe;
  logic [VL_W-1:0] vlReg;
  logic [IDX_W-1:0] idx;
  opSel_e opReg;
  logic seen, srcBit, actBit, newBit, illComb;

  assign illComb  = (vdIdx == vs2Idx) || (!vm && (vdIdx == '0)) ||
                    (opSel == OP_RSVD);
  assign startBad = illComb || (vl == '0);
  assign lastElem = ((VL_W'(idx) + VL_W'(1)) == vlReg);

  assign srcBit = srcSnap[idx];
  assign actBit = actSnap[idx];

  always_comb begin
    case (opReg)
      OP_BEFORE: newBit = !seen && !srcBit;
      OP_INCL:   newBit = !seen;
      OP_ONLY:   newBit = !seen && srcBit;
      default:   newBit = 1'b0;
    endcase
  end

  // one write enable per destination bit
  for (genvar g = 0; g < VLEN; g++) begin : g_we
    assign bitWe[g] = strobe.step && actBit && (idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSnap <= '0;
      actSnap <= '0;
      destReg <= '0;
      vlReg   <= '0;
      idx     <= '0;
      opReg   <= OP_BEFORE;
      seen    <= 1'b0;
      illFlag <= 1'b0;
    end else if (strobe.load) begin
      srcSnap <= srcMask;
      actSnap <= vm ? '1 : execMask;
      destReg <= oldDest;
      vlReg   <= vl;
      idx     <= '0;
      opReg   <= opSel_e'(opSel);
      seen    <= 1'b0;
      illFlag <= illComb;
    end else if (strobe.step) begin
      for (int b = 0; b < VLEN; b++)
        if (bitWe[b]) destReg[b] <= newBit;
      if (actBit && srcBit) seen <= 1'b1;
      idx <= idx + IDX_W'(1);
    end
  end

  assign destOut = destReg;
endmodule

// File: rtl/mask_first_unit.sv
module mask_first_unit
  import mfo_pkg::*;
#(
  parameter int VLEN      = 64,
  parameter int REG_IDX_W = 5,
  localparam int VL_W     = $clog2(VLEN + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           opSel,
  input  logic                 vm,
  input  logic [VL_W-1:0]      vl,
  input  logic [REG_IDX_W-1:0] vdIdx,
  input  logic [REG_IDX_W-1:0] vs2Idx,
  input  logic [VLEN-1:0]      srcMask,
  input  logic [VLEN-1:0]      execMask,
  input  logic [VLEN-1:0]      oldDest,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal,
  output logic [VLEN-1:0]      newDest
);
  ctrlStrobe_t strobe;
  logic startBad, lastElem, illFlag;

  mfo_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .startBad(startBad),
    .lastElem(lastElem), .strobe(strobe), .busy(busy), .done(done)
  );

  mfo_datapath #(.VLEN(VLEN), .REG_IDX_W(REG_IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSel(opSel), .vm(vm),
    .vl(vl), .vdIdx(vdIdx), .vs2Idx(vs2Idx), .srcMask(srcMask),
    .execMask(execMask), .oldDest(oldDest), .startBad(startBad),
    .lastElem(lastElem), .illFlag(illFlag), .destOut(newDest)
  );

  assign illegal = done && illFlag;
endmodule

// File: rtl/mfo_chk.sv
module mfo_chk #(
  parameter int VLEN      = 64,
  parameter int REG_IDX_W = 5,
  localparam int VL_W     = $clog2(VLEN + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic [1:0]           opSel,
  input logic                 vm,
  input logic [VL_W-1:0]      vl,
  input logic [REG_IDX_W-1:0] vdIdx,
  input logic [REG_IDX_W-1:0] vs2Idx,
  input logic [VLEN-1:0]      oldDest,
  input logic                 busy,
  input logic                 done,
  input logic                 illegal,
  input logic [VLEN-1:0]      newDest
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  // R7
  overlap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (vdIdx == vs2Idx)) |=> (done && illegal));

  // R8
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (opSel == 2'b11)) |=> (done && illegal));

  // R9
  illegal_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegal) |-> (newDest == $past(oldDest)));

  // R10
  empty_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (vl == '0)) |=> done);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(newDest));
endmodule

bind mask_first_unit mfo_chk #(.VLEN(VLEN), .REG_IDX_W(REG_IDX_W)) i_chk (.*);

// File: tb/test_mask_first_unit.sv
module test_mask_first_unit;
  localparam int VLEN = 16;
  localparam int RW   = 5;
  localparam int VLW  = $clog2(VLEN + 1);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, vm = 1'b1;
  logic [1:0] opSel = '0;
  logic [VLW-1:0] vl = '0;
  logic [RW-1:0] vdIdx = '0, vs2Idx = '0;
  logic [VLEN-1:0] srcMask = '0, execMask = '0, oldDest = '0;
  logic busy, done, illegal;
  logic [VLEN-1:0] newDest;

  always #10 clk = ~clk;  // 50 MHz

  mask_first_unit #(.VLEN(VLEN), .REG_IDX_W(RW)) i_mask_first_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .vm(vm), .vl(vl),
    .vdIdx(vdIdx), .vs2Idx(vs2Idx), .srcMask(srcMask), .execMask(execMask),
    .oldDest(oldDest), .busy(busy), .done(done), .illegal(illegal),
    .newDest(newDest)
  );

  typedef struct {
    logic [VLEN-1:0] dest;
    logic            ill;
    int              lat;
    int              startCyc;
    string           tag;
  } item_t;

  item_t expQ[$];
  int nTests = 0, nFail = 0, cyc = 0;
  logic [VLEN-1:0] lastDest = '0;

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      finishRun();
    end
  end

  // reference model written from the requirements
  function automatic item_t refModel(input logic [1:0] op, input logic vmv,
      input int vlv, input int vd, input int vs2, input logic [VLEN-1:0] src,
      input logic [VLEN-1:0] act, input logic [VLEN-1:0] old);
    item_t r;
    logic found = 1'b0;
    r.dest = old;
    r.ill = (vd == vs2) || (!vmv && vd == 0) || (op == 2'b11);
    r.lat = (r.ill || vlv == 0) ? 1 : vlv + 1;
    if (!r.ill) begin
      for (int i = 0; i < vlv; i++) begin
        if (vmv || act[i]) begin
          case (op)
            2'b00: r.dest[i] = !found && !src[i];
            2'b01: r.dest[i] = !found;
            default: r.dest[i] = !found && src[i];
          endcase
          if (src[i]) found = 1'b1;
        end
      end
    end
    return r;
  endfunction

  // driver: optional intruding start while busy (R12)
  task automatic doOp(input string tag, input logic [1:0] op, input logic vmv,
      input int vlv, input int vd, input int vs2, input logic [VLEN-1:0] src,
      input logic [VLEN-1:0] act, input logic [VLEN-1:0] old,
      input bit intrude);
    item_t it;
    @(negedge clk);
    it = refModel(op, vmv, vlv, vd, vs2, src, act, old);
    it.tag = tag;
    it.startCyc = cyc;
    expQ.push_back(it);
    lastDest = it.dest;
    opSel = op; vm = vmv; vl = VLW'(vlv); vdIdx = RW'(vd); vs2Idx = RW'(vs2);
    srcMask = src; execMask = act; oldDest = old; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      @(negedge clk);
      opSel = 2'b01; vm = 1'b1; vl = VLW'(VLEN); vdIdx = 5'd3; vs2Idx = 5'd4;
      srcMask = '0; oldDest = ~old; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  // monitor: pops expected results on each done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        nTests++; nFail++;
        $display("FAIL R12 extra done: actual 1 expected 0");
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(e.tag, 64'(newDest), 64'(e.dest), "newDest");
        check(e.tag, 64'(illegal), 64'(e.ill), "illegal");
        check("R10", 64'(cyc - e.startCyc), 64'(e.lat), "latency");
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", 64'(busy), 64'd0, "busy");
    check("R13", 64'(done), 64'd0, "done");
    check("R13", 64'(illegal), 64'd0, "illegal");
    check("R13", 64'(newDest), 64'd0, "newDest");
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doOp("R1", 2'b00, 1, 16, 2, 5, 16'h0010, 16'h0000, 16'h0000, 0);
    doOp("R2", 2'b01, 1, 16, 2, 5, 16'h0010, 16'h0000, 16'h0000, 0);
    doOp("R3", 2'b10, 1, 16, 2, 5, 16'h0010, 16'h0000, 16'h0000, 0);
    doOp("R3", 2'b10, 1, 16, 2, 5, 16'h0000, 16'h0000, 16'hFFFF, 0);
    doOp("R1", 2'b00, 1, 16, 2, 5, 16'h0001, 16'h0000, 16'hFFFF, 0);
    // R4 inactive set bit at 2 does not count, old bits kept
    doOp("R4", 2'b01, 0, 16, 2, 5, 16'h0104, 16'hFF0B, 16'h00F0, 0);
    doOp("R4", 2'b10, 0, 16, 7, 5, 16'h0C04, 16'hF0F3, 16'h5A5A, 0);
    // R5 tail kept
    doOp("R5", 2'b00, 1, 8, 2, 5, 16'h0000, 16'h0000, 16'hA500, 0);
    doOp("R5", 2'b01, 1, 5, 2, 5, 16'h0040, 16'h0000, 16'h3CC3, 0);
    // R6 execMask ignored when vm=1
    doOp("R6", 2'b10, 1, 16, 0, 5, 16'h0300, 16'h0000, 16'h0000, 0);
    // R7 overlap and masked v0
    doOp("R7", 2'b00, 1, 16, 4, 4, 16'h0010, 16'h0000, 16'h1234, 0);
    doOp("R7", 2'b01, 0, 16, 0, 4, 16'h0010, 16'hFFFF, 16'h4321, 0);
    // R8 reserved code
    doOp("R8", 2'b11, 1, 16, 2, 5, 16'h0010, 16'h0000, 16'hBEEF, 0);
    // R10 empty length
    doOp("R10", 2'b01, 1, 0, 2, 5, 16'h0010, 16'h0000, 16'h0F0F, 0);
    // R12 start while busy ignored
    doOp("R12", 2'b00, 1, 12, 2, 5, 16'h0200, 16'h0000, 16'hC000, 1);
    // R11 result held while idle
    repeat (4) @(negedge clk);
    check("R11", 64'(newDest), 64'(lastDest), "held newDest");
    // R9 mixed random traffic, including illegal combinations
    for (int k = 0; k < 60; k++) begin
      doOp("R9", 2'($urandom), 1'($urandom), int'($urandom % 17),
           int'($urandom % 4), int'($urandom % 4), 16'($urandom),
           16'($urandom), 16'($urandom), 0);
    end
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nTests++; nFail++;
      $display("FAIL R10 missing done: actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end
endmodule